// File: doc/BRIEF.md
# Processor C-State and Throttle Arbiter

This block decides, cycle by cycle, how the processor clock is gated while the system is awake. It tracks five states: running (C0), halted (C1), stop-clock (C2), stop-clock entered from halt, and sleep-pending. In the running state it can duty-cycle a stop-clock line. Throttling is requested either by a software enable or by an active-low thermal input.

The requests are ranked in one fixed order. A sleep request beats everything. A level-2 read strobe comes next, and it beats both thermal and software throttling. Throttling is active only while the block is running. The block remembers whether stop-clock was entered from halt, so a break event returns it to halt or to running as appropriate. An interrupt that arrives while halted is forwarded to the processor as a one-cycle pulse.

All outputs are registered. The throttle period and the stopped portion of each period are set through configuration inputs, counted in clock cycles.

Top module: `cst_arbiter`

## Requirements
- R1: The state encoding on `state_o` is running=0, halt=1, stop=2, stop-from-halt=3, sleep-pending=4. After reset the state is 0, with `stop_clk`=0 and `intr_out`=0.
- R2: A clock edge that sees `sleep_en`=1 moves the state to 4 from any state. The state then stays at 4 until reset, whatever the other inputs do.
- R3: Whenever the state is 2, 3 or 4 at an edge, `stop_clk` is 1 after that edge. This holds with no duty cycling, even while thermal or software throttling is requested.
- R4: A level-2 read strobe without `sleep_en` moves the state from 0 to 2 and from 1 to 3 at the next edge. In states 2 and 3 the strobe keeps the state where it is. In state 0 the strobe wins over `halt`, and in states 2 and 3 it wins over `brk_evt`.
- R5: In state 2, a break event (with no strobe and no sleep request) returns the state to 0. If throttling is still requested, duty cycling then resumes, starting a fresh period.
- R6: In state 3, a break event returns the state to 1, not to 0.
- R7: In state 0, `halt` (with no strobe and no sleep request) moves the state to 1. In state 1, `stop_clk` is 0.
- R8: In state 1, `intr_in` (with no strobe and no sleep request) moves the state to 0. `intr_out` is 1 for exactly that one cycle, alongside the new state 0.
- R9: Throttle timing, with P the effective period and D the effective stopped count:
  - While the state is 0 and throttling is requested, a cycle counter runs from 0 to P-1 and then wraps.
  - The counter restarts at 0 on the first running cycle with a request.
  - `stop_clk` after an edge is 1 exactly when the counter value at that edge is at least P-D.
  - With no request, the counter is cleared and `stop_clk` is 0 in state 0.
- R10: Throttling is requested when `sw_thr_en`=1 or `therm_n`=0. With `sw_thr_en`=0, thermal throttling still runs.
- R11: A `period_cfg` of 0 is treated as a period of 1. A `duty_cfg` larger than the period is clamped to the period, so the clock is always stopped. A `duty_cfg` of 0 never stops the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_thr_en | input | 1 | Software throttle enable |
| therm_n | input | 1 | Active-low thermal throttle request |
| l2_rd | input | 1 | Level-2 read strobe (enter stop-clock) |
| halt | input | 1 | Processor halt indication |
| brk_evt | input | 1 | Break event, exits stop-clock |
| intr_in | input | 1 | Interrupt request, wakes from halt |
| sleep_en | input | 1 | Sleep request |
| period_cfg | input | PW | Throttle period in cycles |
| duty_cfg | input | PW | Stopped cycles per period |
| stop_clk | output | 1 | Stop-clock line (1 = stop) |
| intr_out | output | 1 | Interrupt forwarded to processor |
| state_o | output | 3 | Current state code |

## Verification
Every result is due exactly one clock edge after the inputs that cause it:
- The state and the interrupt pulse change at the edge that samples the request.
- The stop-clock line is computed from the state and counter held before that edge, so it trails a state change by one edge.

The bench drives inputs at falling edges. At each rising edge its requirement-based model computes what that edge must produce and queues it. A monitor pops the queue at the next falling edge and compares. Every output is therefore checked in every cycle, in the cycle it is due, including the first throttled cycle after a stop-clock exit.

// File: rtl/cst_pkg.sv
package cst_pkg;

  typedef enum logic [2:0] {
    CS_RUN       = 3'd0,
    CS_HALT      = 3'd1,
    CS_STOP      = 3'd2,
    CS_STOP_HALT = 3'd3,
    CS_SLEEP     = 3'd4
  } cst_state_e;

  // States in which the stop-clock line is held continuously
  function automatic logic stop_forced(input cst_state_e s);
    return (s == CS_STOP) || (s == CS_STOP_HALT) || (s == CS_SLEEP);
  endfunction

  // Fixed priority: sleep, level-2 read, then per-state events
  function automatic cst_state_e next_state(
    input cst_state_e s,
    input logic       slp,
    input logic       l2,
    input logic       hlt,
    input logic       brk,
    input logic       irq
  );
    cst_state_e n;
    n = s;
    if (s == CS_SLEEP) begin
      n = CS_SLEEP;
    end else if (slp) begin
      n = CS_SLEEP;
    end else if (l2) begin
      case (s)
        CS_RUN:  n = CS_STOP;
        CS_HALT: n = CS_STOP_HALT;
        default: n = s;
      endcase
    end else begin
      case (s)
        CS_RUN:       n = hlt ? CS_HALT : CS_RUN;
        CS_HALT:      n = irq ? CS_RUN : CS_HALT;
        CS_STOP:      n = brk ? CS_RUN : CS_STOP;
        CS_STOP_HALT: n = brk ? CS_HALT : CS_STOP_HALT;
        default:      n = s;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/cst_thr_timer.sv
module cst_thr_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period_cfg,
  input  logic [PW-1:0] duty_cfg,
  output logic          stop_phase
);

  localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  function automatic logic [PW-1:0] eff_period(input logic [PW-1:0] p);
    return (p == '0) ? ONE : p;
  endfunction

  function automatic logic [PW-1:0] eff_duty(input logic [PW-1:0] d,
                                             input logic [PW-1:0] p);
    return (d > p) ? p : d;
  endfunction

  logic [PW-1:0] per_w, duty_w, thresh_w, cnt_q;
  logic [PW:0]   cnt_inc_w;
  logic          wrap_w;

  assign per_w     = eff_period(period_cfg);
  assign duty_w    = eff_duty(duty_cfg, per_w);
  assign thresh_w  = per_w - duty_w;
  assign cnt_inc_w = {1'b0, cnt_q} + {{PW{1'b0}}, 1'b1};
  assign wrap_w    = cnt_inc_w >= {1'b0, per_w};

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (wrap_w) cnt_q <= '0;
    else             cnt_q <= cnt_inc_w[PW-1:0];
  end

  assign stop_phase = run && (cnt_q >= thresh_w);

  AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/cst_state_fsm.sv
module cst_state_fsm
  import cst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_en,
  input  logic       l2_rd,
  input  logic       halt,
  input  logic       brk_evt,
  input  logic       intr_in,
  output cst_state_e state_q,
  output logic       intr_q
);

  cst_state_e nxt_w;
  logic       wake_w;

  assign nxt_w  = next_state(state_q, sleep_en, l2_rd, halt, brk_evt, intr_in);
  assign wake_w = (state_q == CS_HALT) && (nxt_w == CS_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CS_RUN;
      intr_q  <= 1'b0;
    end else begin
      state_q <= nxt_w;
      intr_q  <= wake_w;
    end
  end

  AST_SLEEP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_en |=> (state_q == CS_SLEEP)); // R2
  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_SLEEP) |=> (state_q == CS_SLEEP)); // R2
  AST_L2_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_RUN && l2_rd && !sleep_en) |=> (state_q == CS_STOP)); // R4
  AST_L2_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_HALT && l2_rd && !sleep_en) |=> (state_q == CS_STOP_HALT)); // R4
  AST_STOP_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_STOP && brk_evt && !l2_rd && !sleep_en) |=> (state_q == CS_RUN)); // R5
  AST_STOP_HALT_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_STOP_HALT && brk_evt && !l2_rd && !sleep_en) |=> (state_q == CS_HALT)); // R6
  AST_INTR_ONLY_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    intr_q |-> (state_q == CS_RUN && $past(state_q) == CS_HALT)); // R8

endmodule

// File: rtl/cst_arbiter.sv
module cst_arbiter
  import cst_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_thr_en,
  input  logic          therm_n,
  input  logic          l2_rd,
  input  logic          halt,
  input  logic          brk_evt,
  input  logic          intr_in,
  input  logic          sleep_en,
  input  logic [PW-1:0] period_cfg,
  input  logic [PW-1:0] duty_cfg,
  output logic          stop_clk,
  output logic          intr_out,
  output logic [2:0]    state_o
);

  cst_state_e state_w;
  logic       intr_w;
  logic       thr_req_w;
  logic       thr_run_w;
  logic       stop_phase_w;
  logic       stop_d_w;
  logic       stop_q;

  cst_state_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_en (sleep_en),
    .l2_rd    (l2_rd),
    .halt     (halt),
    .brk_evt  (brk_evt),
    .intr_in  (intr_in),
    .state_q  (state_w),
    .intr_q   (intr_w)
  );

  // Throttle request: software enable or active-low thermal input
  assign thr_req_w = sw_thr_en | ~therm_n;
  assign thr_run_w = (state_w == CS_RUN) && thr_req_w;

  cst_thr_timer #(.PW(PW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (thr_run_w),
    .period_cfg (period_cfg),
    .duty_cfg   (duty_cfg),
    .stop_phase (stop_phase_w)
  );

  assign stop_d_w = stop_forced(state_w) | stop_phase_w;

  always_ff @(posedge clk) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= stop_d_w;
  end

  assign stop_clk = stop_q;
  assign intr_out = intr_w;
  assign state_o  = state_w;

  AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == CS_STOP || state_w == CS_STOP_HALT || state_w == CS_SLEEP) |=> stop_clk); // R3
  AST_HALT_RUNS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == CS_HALT) |=> !stop_clk); // R7
  AST_NO_REQ_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == CS_RUN && !sw_thr_en && therm_n) |=> !stop_clk); // R10

endmodule

// File: tb/cst_arbiter_test.sv
module cst_arbiter_test;

  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_thr_en = 1'b0, therm_n = 1'b1, l2_rd = 1'b0, halt = 1'b0;
  logic          brk_evt = 1'b0, intr_in = 1'b0, sleep_en = 1'b0;
  logic [PW-1:0] period_cfg = 8'd4, duty_cfg = 8'd1;
  logic          stop_clk, intr_out;
  logic [2:0]    state_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  cst_arbiter #(.PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .sw_thr_en(sw_thr_en), .therm_n(therm_n),
    .l2_rd(l2_rd), .halt(halt), .brk_evt(brk_evt), .intr_in(intr_in),
    .sleep_en(sleep_en), .period_cfg(period_cfg), .duty_cfg(duty_cfg),
    .stop_clk(stop_clk), .intr_out(intr_out), .state_o(state_o)
  );

  // Scoreboard queues: expected {state, stop, intr} and requirement tag
  logic [4:0] exp_q[$];
  string      tag_q[$];

  // Requirement model, evaluated at each rising edge
  int m_st = 0;
  int m_cnt = 0;
  always @(posedge clk) begin
    int p, d, ns, nc;
    bit thr, nstop, nintr;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; nstop = 0; nintr = 0;
    end else begin
      p = (period_cfg == 0) ? 1 : int'(period_cfg);
      d = (int'(duty_cfg) > p) ? p : int'(duty_cfg);
      thr = sw_thr_en || !therm_n;
      nstop = (m_st >= 2) || (m_st == 0 && thr && m_cnt >= p - d);
      if (m_st == 0 && thr) nc = (m_cnt + 1 >= p) ? 0 : m_cnt + 1;
      else nc = 0;
      ns = m_st;
      nintr = 0;
      if (m_st == 4 || sleep_en) ns = 4;
      else if (l2_rd) ns = (m_st == 0) ? 2 : (m_st == 1) ? 3 : m_st;
      else if (m_st == 0 && halt) ns = 1;
      else if (m_st == 1 && intr_in) begin ns = 0; nintr = 1; end
      else if (m_st == 2 && brk_evt) ns = 0;
      else if (m_st == 3 && brk_evt) ns = 1;
      m_st = ns; m_cnt = nc;
    end
    exp_q.push_back({m_st[2:0], nstop, nintr});
    tag_q.push_back(tag);
  end

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    logic [4:0] e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if ({state_o, stop_clk, intr_out} !== e) begin
        n_bad++;
        $display("FAIL %s: state=%0d stop=%0b intr=%0b expected state=%0d stop=%0b intr=%0b",
                 t, state_o, stop_clk, intr_out, e[4:2], e[1], e[0]);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; step(1); sig = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(3); rst_n = 1'b1;
  endtask

  initial begin
    tag = "R1"; do_reset(); step(2);
    // R9: software throttling, period 4, one stopped cycle
    tag = "R9"; sw_thr_en = 1; step(20);
    // R10: thermal only, software disabled, period 5 duty 2
    tag = "R10"; sw_thr_en = 0; therm_n = 0; period_cfg = 8'd5; duty_cfg = 8'd2; step(15);
    // R4: level-2 read overrides thermal throttling
    tag = "R4"; pulse(l2_rd); step(6);
    // R3: stop-clock held, break during strobe ignored
    tag = "R3"; l2_rd = 1; brk_evt = 1; step(1); l2_rd = 0; brk_evt = 0; step(3);
    // R5: break returns to run, throttling resumes from fresh period
    tag = "R5"; pulse(brk_evt); step(12);
    therm_n = 1;
    // R7: halt, clock runs in halt
    tag = "R7"; pulse(halt); step(4);
    // R4: strobe from halt goes to stop-from-halt
    tag = "R4"; pulse(l2_rd); step(3);
    // R6: break from stop-from-halt returns to halt
    tag = "R6"; pulse(brk_evt); step(3);
    // R8: interrupt wakes halt and is forwarded for one cycle
    tag = "R8"; pulse(intr_in); step(4);
    // R4: strobe and halt together in run -> stop
    tag = "R4"; l2_rd = 1; halt = 1; step(1); l2_rd = 0; halt = 0; step(2);
    tag = "R5"; pulse(brk_evt); step(2);
    // R11: period 0 / duty 0 never stops; duty above period always stops
    tag = "R11"; sw_thr_en = 1; period_cfg = 0; duty_cfg = 0; step(5);
    duty_cfg = 8'd3; step(5);
    period_cfg = 8'd3; duty_cfg = 8'd7; step(6);
    period_cfg = 8'd6; duty_cfg = 0; step(8);
    period_cfg = 8'd3; duty_cfg = 8'd2; step(9);
    // R2: sleep wins and holds; R3 continuous stop despite thermal
    tag = "R2"; therm_n = 0; period_cfg = 8'd4; duty_cfg = 8'd1; pulse(sleep_en); step(3);
    tag = "R3"; step(6);
    tag = "R2"; pulse(l2_rd); pulse(brk_evt); pulse(intr_in); step(4);
    // R1: reset returns to the idle encoding
    tag = "R1"; sw_thr_en = 0; therm_n = 1; do_reset(); step(3);
    // R2: sleep from halt
    tag = "R2"; pulse(halt); step(1); sleep_en = 1; halt = 1; step(1); sleep_en = 0; halt = 0; step(4);
    step(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule